// File: doc/BRIEF.md
# EEPROM Page Write Buffer Controller

This block sits behind the slave engine of a serial EEPROM model. It gathers the data bytes of one write transaction in a page-sized buffer. When the transaction ends with a Stop, it commits the buffer to a byte-wide register-file array. The engine loads a starting address and then presents data bytes one at a time with a valid strobe. It also signals Stop, or an abort when a repeated Start arrives. A write-protect level is sampled as the Stop is seen.

After a commit, the block raises a busy flag for a programmable number of clock cycles, which stands for the self-timed program cycle. The engine uses this flag to withhold its acknowledge. A second, read-only port lets the engine fetch array bytes while the block is idle.

The array holds 2^ADDR_W bytes and pages hold 2^PAGE_W bytes (64 by default). An address splits into a page number (`addr[ADDR_W-1:PAGE_W]`) and a slot within the page (`addr[PAGE_W-1:0]`).

Top module: `eeprom_page_writer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `busy_o` and `rd_vld_o` are 0.
- R2: A data byte is stored in the slot given by the current low address bits, `addr[5:0]`. After each byte, only those six bits increment, modulo 64. A write that starts at slot 62 therefore fills slots 62, 63 and 0 of the same page, and the next page is left untouched.
- R3: When more than 64 bytes arrive before the Stop, the slot index wraps. The later bytes replace the earlier ones in arrival order, so byte k lands in slot (start + k) mod 64.
- R4: The array keeps its old contents until a Stop ends the write. A read made while bytes are still being collected returns the old value.
- R5: A Stop with at least one collected byte and `wp_i` low starts a program cycle. `busy_o` goes high on the cycle after the Stop and stays high for exactly PROG_CYCLES cycles.
- R6: When `wp_i` is high in the Stop cycle, nothing is written and `busy_o` stays low.
- R7: `wp_i` counts only in the Stop cycle. Its level while data arrives, and any change after the Stop, have no effect on the commit.
- R8: A partial-page write leaves the slots that were not sent at their previous values.
- R9: An abort discards the collected bytes without a commit. A Stop with no collected byte, whether after an abort or after a bare address load, starts no program cycle.
- R10: A read request made while `busy_o` is low returns `rd_data_o` with `rd_vld_o` high on the next cycle. A request made while `busy_o` is high produces no `rd_vld_o`.
- R11: While `busy_o` is high, address loads, data bytes, Stops and aborts are all ignored. They neither change the array nor extend or restart the program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load_i | input | 1 | Starts a write transaction at `addr_i` |
| addr_i | input | ADDR_W | Starting byte address |
| data_vld_i | input | 1 | One data byte is present on `data_i` |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop ends the transaction |
| abort_i | input | 1 | Repeated Start; pending data is dropped |
| wp_i | input | 1 | Write-protect level, used in the Stop cycle |
| busy_o | output | 1 | Program cycle in progress |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data |

## Verification
`busy_o` is due one cycle after the Stop is sampled and falls exactly PROG_CYCLES cycles later. `rd_data_o` with `rd_vld_o` is due one cycle after `rd_en_i`. The bench drives every input on a falling edge and samples on the next falling edge, which is one rising edge later. It counts the falling edges on which `busy_o` is high to measure the program-cycle length. A queue of expected read bytes is popped only when `rd_vld_o` appears, so a response that is missing, extra or late becomes a mismatch.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 6,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_vld_i,
  input  logic [7:0]        data_i,
  input  logic              stop_i,
  input  logic              abort_i,
  input  logic              wp_i,
  output logic              busy_o,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_vld_o,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [SLOTS];
  logic [SLOTS-1:0] dirty;
  logic [ROW_W-1:0] row_q;
  logic [PAGE_W-1:0] slot_q;
  logic             have_data;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  wire idle      = !busy_q;
  wire take_stop = idle && !addr_load_i && !abort_i && stop_i;
  wire take_byte = idle && !addr_load_i && !abort_i && !stop_i && data_vld_i;
  wire commit    = take_stop && have_data && !wp_i;

  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      have_data <= 1'b0;
      dirty     <= '0;
      row_q     <= '0;
      slot_q    <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (addr_load_i) begin
      row_q     <= addr_i[ADDR_W-1:PAGE_W];
      slot_q    <= addr_i[PAGE_W-1:0];
      have_data <= 1'b0;
      dirty     <= '0;
    end else if (abort_i) begin
      have_data <= 1'b0;
      dirty     <= '0;
    end else if (stop_i) begin
      have_data <= 1'b0;
      dirty     <= '0;
      if (commit) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(PROG_CYCLES - 1);
      end
    end else if (data_vld_i) begin
      dirty[slot_q] <= 1'b1;
      slot_q        <= slot_q + 1'b1;
      have_data     <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (take_byte) pbuf[slot_q] <= data_i;

  always_ff @(posedge clk)
    if (commit)
      for (int i = 0; i < SLOTS; i++)
        mem[{row_q, PAGE_W'(i)}] <= dirty[i] ? pbuf[i] : mem[{row_q, PAGE_W'(i)}];

  always_ff @(posedge clk) begin
    if (!rst_n) rd_vld_o <= 1'b0;
    else        rd_vld_o <= rd_en_i && idle;
    if (rd_en_i && idle) rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int PROG_CYCLES = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic stop_i,
  input logic wp_i,
  input logic busy_o,
  input logic have_data,
  input logic rd_en_i,
  input logic rd_vld_o
);
  int run_q;

  always_ff @(posedge clk)
    if (!rst_n)      run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;

  // R5
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_q == PROG_CYCLES);

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && wp_i && !busy_o) |=> !busy_o);

  // R9
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !have_data && !busy_o) |=> !busy_o);

  // R10
  rd_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !busy_o) |=> rd_vld_o);

  // R10
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !rd_vld_o);
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .wp_i(wp_i), .busy_o(busy_o),
  .have_data(have_data), .rd_en_i(rd_en_i), .rd_vld_o(rd_vld_o)
);

// File: tb/tb_eeprom_page_writer.sv
module tb_eeprom_page_writer;
  localparam int AW = 10;
  localparam int P  = 40;

  logic clk = 0, rst_n = 0;
  logic addr_load_i = 0, data_vld_i = 0, stop_i = 0, abort_i = 0, wp_i = 0, rd_en_i = 0;
  logic [AW-1:0] addr_i = '0, rd_addr_i = '0;
  logic [7:0] data_i = '0;
  logic busy_o, rd_vld_o;
  logic [7:0] rd_data_o;

  eeprom_page_writer #(.ADDR_W(AW), .PAGE_W(6), .PROG_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .data_vld_i(data_vld_i), .data_i(data_i), .stop_i(stop_i), .abort_i(abort_i),
    .wp_i(wp_i), .busy_o(busy_o), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] model [1 << AW];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  int  b_row, b_slot;
  bit  b_have;
  logic [7:0] b_buf [64];
  bit  b_dirty [64];
  int  bcnt;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && rd_vld_o) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected rd_vld", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rd_data_o === e, t, rd_data_o, e);
      end
    end

  task automatic tick(); @(negedge clk); endtask

  task automatic rd(int a, string req);
    exp_q.push_back(model[a]); tag_q.push_back(req);
    rd_en_i = 1; rd_addr_i = AW'(a); tick(); rd_en_i = 0;
    tick();
  endtask

  task automatic t_load(int a);
    addr_load_i = 1; addr_i = AW'(a); tick(); addr_load_i = 0;
    b_row = a / 64; b_slot = a % 64; b_have = 0;
    for (int i = 0; i < 64; i++) b_dirty[i] = 0;
  endtask

  task automatic t_byte(logic [7:0] d);
    data_vld_i = 1; data_i = d; tick(); data_vld_i = 0;
    b_buf[b_slot] = d; b_dirty[b_slot] = 1; b_slot = (b_slot + 1) % 64; b_have = 1;
  endtask

  task automatic t_stop(bit wp, bit wp_after, string req);
    bit exp_busy;
    wp_i = wp; stop_i = 1; tick(); stop_i = 0; wp_i = wp_after;
    exp_busy = b_have && !wp;
    if (exp_busy)
      for (int i = 0; i < 64; i++) if (b_dirty[i]) model[b_row*64 + i] = b_buf[i];
    b_have = 0;
    for (int i = 0; i < 64; i++) b_dirty[i] = 0;
    chk(busy_o === exp_busy, req, busy_o, exp_busy);
    if (exp_busy) begin
      bcnt = 0;
      while (busy_o) begin bcnt++; tick(); end
      chk(bcnt == P, "R5 busy length", bcnt, P);
    end else begin
      for (int i = 0; i < 3; i++) begin tick(); chk(busy_o === 1'b0, req, busy_o, 0); end
    end
    wp_i = 0;
  endtask

  task automatic t_abort();
    abort_i = 1; tick(); abort_i = 0;
    b_have = 0;
    for (int i = 0; i < 64; i++) b_dirty[i] = 0;
    chk(busy_o === 1'b0, "R9 abort no busy", busy_o, 0);
  endtask

  task automatic txn(int a, int n, int seed, bit wp_d, bit wp_s, bit wp_a, string req);
    t_load(a);
    wp_i = wp_d;
    for (int i = 0; i < n; i++) t_byte(8'(seed * 13 + i * 7 + 1));
    t_stop(wp_s, wp_a, req);
  endtask

  task automatic tick_count(); tick(); if (busy_o) bcnt++; endtask

  initial begin
    repeat (3) tick();
    chk(busy_o === 1'b0, "R1 busy reset", busy_o, 0);
    chk(rd_vld_o === 1'b0, "R1 rd_vld reset", rd_vld_o, 0);
    rst_n = 1; tick();
    chk(busy_o === 1'b0, "R1 busy after reset", busy_o, 0);

    for (int p = 0; p < 4; p++) txn(p * 64, 64, p + 1, 0, 0, 0, "R5 busy after full page");
    rd(0, "R2 slot 0"); rd(63, "R2 slot 63"); rd(64 + 17, "R2 page1 slot 17");

    txn(64 + 62, 3, 9, 0, 0, 0, "R5 wrap write busy");
    rd(64 + 62, "R2 wrap slot 62"); rd(64 + 63, "R2 wrap slot 63");
    rd(64 + 0, "R2 wrap to slot 0"); rd(64 + 1, "R2 slot 1 kept");
    rd(128, "R2 next page untouched");

    t_load(5); t_byte(8'hA5);
    rd(5, "R4 old value before stop"); rd(6, "R4 neighbour before stop");
    t_stop(0, 0, "R5 busy after single byte");
    rd(5, "R4 new value after stop");

    txn(10, 2, 21, 0, 0, 0, "R5 partial busy");
    rd(9, "R8 below partial"); rd(10, "R8 written 10"); rd(11, "R8 written 11"); rd(12, "R8 above partial");

    txn(192, 70, 33, 0, 0, 0, "R5 overflow busy");
    rd(192, "R3 slot 0 replaced"); rd(197, "R3 slot 5 replaced");
    rd(198, "R3 slot 6 first pass"); rd(255, "R3 slot 63");

    txn(0, 4, 44, 0, 1, 0, "R6 protected no busy");
    rd(0, "R6 slot 0 unchanged"); rd(3, "R6 slot 3 unchanged");

    txn(20, 2, 55, 1, 0, 1, "R7 wp only at stop");
    rd(20, "R7 written 20"); rd(21, "R7 written 21");

    t_load(30); t_abort();
    t_load(30); t_byte(8'h3C); t_abort();
    t_stop(0, 0, "R9 stop after abort");
    rd(30, "R9 aborted byte dropped");
    t_load(30); t_stop(0, 0, "R9 bare stop");

    t_load(40); t_byte(8'h5C);
    stop_i = 1; tick(); stop_i = 0;
    model[40] = 8'h5C;
    chk(busy_o === 1'b1, "R5 busy started", busy_o, 1);
    bcnt = 1;
    addr_load_i = 1; addr_i = AW'(100); tick_count(); addr_load_i = 0;
    data_vld_i = 1; data_i = 8'hEE; tick_count(); data_vld_i = 0;
    stop_i = 1; tick_count(); stop_i = 0;
    rd_en_i = 1; rd_addr_i = AW'(40); tick_count(); rd_en_i = 0;
    tick_count();
    chk(rd_vld_o === 1'b0, "R10 no read while busy", rd_vld_o, 0);
    abort_i = 1; tick_count(); abort_i = 0;
    while (busy_o) tick_count();
    chk(bcnt == P, "R11 busy not extended", bcnt, P);
    stop_i = 1; tick(); stop_i = 0;
    tick();
    chk(busy_o === 1'b0, "R11 ignored byte not pending", busy_o, 0);
    rd(40, "R11 committed byte"); rd(100, "R11 ignored load/data");

    repeat (4) tick();
    chk(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule